// File: doc/BRIEF.md
# Time-Ordered Event Scheduler Queue

This block keeps a bounded set of pending work items, each due at an absolute time. A requester supplies a delay, and the block adds it to the current time index presented on its input. An item is one of two kinds. A generic event carries a handler identifier. An interrupt request carries a line number from 0 to 15. Items are held in slot storage and chained into one list sorted by due time. Unused slots form a second chain that serves as the free pool.

Three commands walk the list, one entry per clock. Insert places a new item behind every item whose due time is equal or earlier. Remove-by-handler drops every event that has a given identifier. Tick takes a fixed amount of 1000 units off every pending due time, stopping at zero. This lets the time index restart from a new base at each millisecond. While no walk is running, the head item is offered on a valid/ready output as soon as its due time has been reached. The block also reports how long it is until the head item is due, together with an empty flag and an occupancy count.

Top module: `evq_sched`

## Requirements
- R1: After reset the queue is empty: `empty_o`=1, `count_o`=0, `busy_o`=0, `out_valid_o`=0 and `next_valid_o`=0.
- R2: An accepted insert sets the item's due time to `now_i + ins_delay_i`. While the list is not empty, `next_wait_o` equals the head's due time minus `now_i`, and it is never less than 1.
- R3: Issue order is ascending due time. Items with equal due times leave in the order they were inserted.
- R4: With all slots in use, an insert is dropped. `err_o` is 1 for the one cycle after the command, and the count and contents stay unchanged.
- R5: Kind encoding is `ins_kind_i`=0 for an event and 1 for an interrupt request. An interrupt's line number is `ins_data_i`. An interrupt insert with a line above 15 is rejected with `err_o` and changes nothing. A line of exactly 15 is accepted.
- R6: `out_valid_o` is 1 only when no walk is running, `cmd_valid_i` is low, the list is not empty and the head's due time is at or below `now_i`. Then `out_kind_i`/`out_data_o` show the head's kind and payload. A cycle with `out_ready_i` high unlinks the head and frees its slot.
- R7: A remove command (`cmd_op_i`=1) unlinks every event whose handler identifier equals `ins_data_i`. Interrupt entries with the same payload value, and events with other identifiers, stay queued in their order.
- R8: A tick command (`cmd_op_i`=2) lowers every pending due time by 1000. A due time of 1000 or less becomes 0.
- R9: Walks visit one entry per clock. `busy_o` is high from the cycle after the command is accepted until the walk ends. A tick or remove over n entries is busy for n+1 cycles, and an insert into an empty list is busy for 1 cycle. Commands are accepted only while `busy_o` is low. `cmd_op_i` is 0 for an insert, and the value 3 does nothing.
- R10: `count_o` always equals the number of queued items, and `empty_o` is high exactly when that number is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_i | input | TW | Current time index |
| cmd_valid_i | input | 1 | Command request, taken when not busy |
| cmd_op_i | input | 2 | 0 insert, 1 remove by handler, 2 tick, 3 no-op |
| ins_kind_i | input | 1 | 0 event, 1 interrupt request |
| ins_data_i | input | HW | Handler identifier or interrupt line |
| ins_delay_i | input | TW | Delay added to now_i on insert |
| busy_o | output | 1 | A list walk is running |
| err_o | output | 1 | One-cycle pulse: insert rejected |
| out_valid_o | output | 1 | Head item is due |
| out_ready_i | input | 1 | Consumer takes the head item |
| out_kind_o | output | 1 | Kind of the offered item |
| out_data_o | output | HW | Payload of the offered item |
| next_valid_o | output | 1 | List not empty |
| next_wait_o | output | TW | Time until head is due, at least 1 |
| empty_o | output | 1 | No items queued |
| count_o | output | CW | Number of queued items |

## Verification
A broken link shows in two ways. Items come out of the output handshake in the wrong order, or they are missing. An item that is never freed leaves `count_o` too high, and the next full-queue test then rejects an insert early. A wrong due time shows at once as a wrong `next_wait_o`. After a tick it shows as an item that is offered too early or too late. Checks of the count and the empty flag after every command catch a lost or duplicated slot within one command.

// File: rtl/evq_sched.sv
module evq_sched #(
  parameter int SLOTS = 128,
  parameter int TW    = 32,
  parameter int HW    = 8,
  parameter int TICK  = 1000,
  localparam int PW   = $clog2(SLOTS) + 1,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic          ins_kind_i,
  input  logic [HW-1:0] ins_data_i,
  input  logic [TW-1:0] ins_delay_i,
  output logic          busy_o,
  output logic          err_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic          out_kind_o,
  output logic [HW-1:0] out_data_o,
  output logic          next_valid_o,
  output logic [TW-1:0] next_wait_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  localparam logic [PW-1:0] NIL = PW'(SLOTS);
  localparam logic [1:0] OP_INS = 2'd0, OP_REM = 2'd1, OP_TICK = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_INS, S_REM, S_TICK} state_t;
  state_t state;

  logic [TW-1:0] due  [SLOTS];
  logic          kind [SLOTS];
  logic [HW-1:0] pay  [SLOTS];
  logic [PW-1:0] nxt  [SLOTS];

  logic [PW-1:0] head, free, cur, prv, ns;
  logic [TW-1:0] key_due;
  logic [HW-1:0] key_id;
  logic [CW-1:0] count;

  wire [PW-2:0] head_i = head[PW-2:0];
  wire [PW-2:0] free_i = free[PW-2:0];
  wire [PW-2:0] cur_i  = cur[PW-2:0];
  wire [PW-2:0] prv_i  = prv[PW-2:0];
  wire [PW-2:0] ns_i   = ns[PW-2:0];

  wire accept  = cmd_valid_i && state == S_IDLE;
  wire full    = free == NIL;
  wire bad     = ins_kind_i && ins_data_i > HW'(15);
  wire has     = head != NIL;
  wire [TW-1:0] new_due = now_i + ins_delay_i;
  wire [TW-1:0] hd    = due[head_i];
  wire [TW-1:0] cdue  = due[cur_i];
  wire [PW-1:0] cnext = nxt[cur_i];
  wire          hit   = !kind[cur_i] && pay[cur_i] == key_id;
  wire          pop   = out_valid_o && out_ready_i;

  assign busy_o       = state != S_IDLE;
  assign out_valid_o  = state == S_IDLE && !cmd_valid_i && has && hd <= now_i;
  assign out_kind_o   = kind[head_i];
  assign out_data_o   = pay[head_i];
  assign next_valid_o = has;
  assign next_wait_o  = !has ? '0 : (hd > now_i ? hd - now_i : TW'(1));
  assign empty_o      = !has;
  assign count_o      = count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      head    <= NIL;
      free    <= '0;
      cur     <= NIL;
      prv     <= NIL;
      ns      <= NIL;
      key_due <= '0;
      key_id  <= '0;
      count   <= '0;
      err_o   <= 1'b0;
      for (int i = 0; i < SLOTS; i++) nxt[i] <= PW'(i + 1);
    end else begin
      err_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            case (cmd_op_i)
              OP_INS: begin
                if (full || bad) begin
                  err_o <= 1'b1;
                end else begin
                  ns           <= free;
                  free         <= nxt[free_i];
                  due[free_i]  <= new_due;
                  kind[free_i] <= ins_kind_i;
                  pay[free_i]  <= ins_data_i;
                  key_due      <= new_due;
                  prv          <= NIL;
                  cur          <= head;
                  state        <= S_INS;
                end
              end
              OP_REM: begin
                key_id <= ins_data_i;
                prv    <= NIL;
                cur    <= head;
                state  <= S_REM;
              end
              OP_TICK: begin
                cur   <= head;
                state <= S_TICK;
              end
              default: ;
            endcase
          end else if (pop) begin
            head         <= nxt[head_i];
            nxt[head_i]  <= free;
            free         <= head;
            count        <= count - 1'b1;
          end
        end
        S_INS: begin
          if (cur == NIL || cdue > key_due) begin
            nxt[ns_i] <= cur;
            if (prv == NIL) head <= ns;
            else            nxt[prv_i] <= ns;
            count <= count + 1'b1;
            state <= S_IDLE;
          end else begin
            prv <= cur;
            cur <= cnext;
          end
        end
        S_REM: begin
          if (cur == NIL) begin
            state <= S_IDLE;
          end else if (hit) begin
            if (prv == NIL) head <= cnext;
            else            nxt[prv_i] <= cnext;
            nxt[cur_i] <= free;
            free       <= cur;
            cur        <= cnext;
            count      <= count - 1'b1;
          end else begin
            prv <= cur;
            cur <= cnext;
          end
        end
        S_TICK: begin
          if (cur == NIL) begin
            state <= S_IDLE;
          end else begin
            due[cur_i] <= (cdue > TW'(TICK)) ? cdue - TW'(TICK) : '0;
            cur        <= cnext;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire [PW-1:0] second = nxt[head_i];

  assert_sorted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && has && second != NIL) |-> hd <= due[second[PW-2:0]]);
  assert_count_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(SLOTS));
  assert_empty_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (head == NIL) == (count == '0));
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op_i == OP_INS && full) |=> err_o && count == $past(count) && !busy_o);
  assert_bad_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op_i == OP_INS && bad) |=> err_o && $stable(count));
  assert_pop_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> count == $past(count) - 1'b1);
  assert_wait_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    next_valid_o |-> next_wait_o != '0);
endmodule

// File: tb/evq_sched_bench.sv
module evq_sched_bench;
  localparam int SLOTS = 128;
  logic clk = 0, rst_n = 0;
  logic [31:0] now = 0, dly = 0;
  logic cv = 0, kd = 0, ordy = 0;
  logic [1:0] op = 0;
  logic [7:0] dat = 0;
  logic busy, err, ov, okind, nv, empty;
  logic [7:0] odata;
  logic [31:0] nwait;
  logic [7:0] cnt;
  int checks = 0, errors = 0, mc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evq_sched u_evq_sched (
    .clk(clk), .rst_n(rst_n), .now_i(now), .cmd_valid_i(cv), .cmd_op_i(op),
    .ins_kind_i(kd), .ins_data_i(dat), .ins_delay_i(dly), .busy_o(busy),
    .err_o(err), .out_valid_o(ov), .out_ready_i(ordy), .out_kind_o(okind),
    .out_data_o(odata), .next_valid_o(nv), .next_wait_o(nwait),
    .empty_o(empty), .count_o(cnt));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] o, input logic k, input logic [7:0] d,
                     input logic [31:0] dl, output logic e, output int bc);
    @(negedge clk);
    cv = 1; op = o; kd = k; dat = d; dly = dl;
    @(negedge clk);
    cv = 0;
    #1;
    e = err;
    bc = 0;
    while (busy) begin
      bc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic ins_ok(input logic k, input logic [7:0] d, input logic [31:0] dl);
    logic e; int bc;
    cmd(2'd0, k, d, dl, e, bc);
    mc++;
    chk(e == 0, "R2 insert err", e, 0);
    chk(cnt == mc && empty == 0, "R10 count after insert", cnt, mc);
  endtask

  task automatic pop(input logic k, input logic [7:0] d, input string req);
    #1;
    chk(ov == 1, {req, " valid"}, ov, 1);
    chk(okind == k && odata == d, {req, " item"}, {okind, odata}, {k, d});
    ordy = 1;
    @(negedge clk);
    ordy = 0;
    mc--;
    #1;
    chk(cnt == mc && empty == (mc == 0), "R10 count after pop", cnt, mc);
  endtask

  // {kind, data, delay}; inserted at now=100
  localparam logic [40:0] VEC [5] = '{
    {1'b0, 8'd5, 32'd50}, {1'b1, 8'd3, 32'd20}, {1'b0, 8'd9, 32'd50},
    {1'b1, 8'd7, 32'd0},  {1'b0, 8'd2, 32'd300}};
  // expected issue order {kind, data}
  localparam logic [8:0] ORD [5] = '{
    {1'b1, 8'd7}, {1'b1, 8'd3}, {1'b0, 8'd5}, {1'b0, 8'd9}, {1'b0, 8'd2}};

  initial begin
    logic e; int bc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(empty == 1 && cnt == 0 && busy == 0 && ov == 0 && nv == 0, "R1 reset state",
        {empty, cnt, busy, ov, nv}, {1'b1, 8'd0, 3'b000});

    // table walk: ordering, equal due times, due-time arithmetic
    now = 100;
    foreach (VEC[i]) ins_ok(VEC[i][40], VEC[i][39:32], VEC[i][31:0]);
    now = 90; #1;
    chk(ov == 0, "R6 not due yet", ov, 0);
    chk(nwait == 10, "R2 next wait", nwait, 10);
    now = 100;
    pop(ORD[0][8], ORD[0][7:0], "R6 due at now");
    chk(ov == 0 && nwait == 20, "R2 wait after pop", nwait, 20);
    now = 150; #1;
    chk(nwait == 1, "R2 minimum wait of one", nwait, 1);
    for (int i = 1; i < 4; i++) pop(ORD[i][8], ORD[i][7:0], "R3 order");
    chk(ov == 0 && nwait == 250, "R6 later item held", nwait, 250);
    now = 400;
    pop(ORD[4][8], ORD[4][7:0], "R3 last");
    chk(empty == 1 && nv == 0, "R10 empty again", empty, 1);

    // remove by handler
    now = 0;
    ins_ok(0, 4, 10); ins_ok(1, 4, 20); ins_ok(0, 4, 30); ins_ok(0, 6, 15); ins_ok(0, 4, 5);
    cmd(2'd1, 0, 4, 0, e, bc);
    mc = 2;
    chk(cnt == 2, "R7 three events removed", cnt, 2);
    chk(bc == 6, "R9 remove walk length", bc, 6);
    now = 5000;
    pop(0, 6, "R7 other id kept");
    pop(1, 4, "R7 interrupt kept");

    // tick rebase
    now = 0;
    ins_ok(0, 1, 500); ins_ok(0, 2, 1000); ins_ok(0, 3, 2500);
    cmd(2'd2, 0, 0, 0, e, bc);
    chk(bc == 4, "R9 tick walk length", bc, 4);
    chk(cnt == 3, "R8 tick keeps items", cnt, 3);
    pop(0, 1, "R8 saturate below");
    pop(0, 2, "R8 saturate at 1000");
    chk(ov == 0 && nwait == 1500, "R8 reduced by 1000", nwait, 1500);
    now = 1500;
    pop(0, 3, "R8 rebased item");

    // no-op command
    cmd(2'd3, 0, 0, 0, e, bc);
    chk(bc == 0 && cnt == 0 && e == 0, "R9 no-op", bc, 0);

    // interrupt line range
    cmd(2'd0, 1, 16, 0, e, bc);
    chk(e == 1 && cnt == 0, "R5 line 16 rejected", {e, cnt}, {1'b1, 8'd0});
    @(negedge clk); #1;
    chk(err == 0, "R5 err one cycle", err, 0);
    ins_ok(1, 15, 0);
    pop(1, 15, "R5 line 15 issued");

    // full queue
    now = 0;
    for (int i = 0; i < SLOTS; i++) ins_ok(0, 8'(i), 32'(i));
    cmd(2'd0, 0, 8'hAA, 0, e, bc);
    chk(e == 1 && cnt == SLOTS, "R4 full insert dropped", cnt, SLOTS);
    now = 1000;
    for (int i = 0; i < SLOTS; i++) pop(0, 8'(i), "R4 contents intact");
    chk(empty == 1, "R4 drained", empty, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule